// File: doc/BRIEF.md
# UART Receive/Transmit DMA Channel

This block moves one direction of a serial port's data between the port and system memory without processor help. Software loads a 32-bit memory address and a 16-bit count of transfers. Each data-ready request from the port then causes one single-beat memory access at that address. When the access is done, the address steps forward by the transfer size and the count drops by one. When the count reaches zero, the channel raises an end flag. That flag drives an interrupt line when its mask bit is set.

The memory side uses a plain handshake. The channel holds `mem_req` until `mem_gnt` accepts the beat, then waits for `mem_done`. Only one beat is ever open at a time. A parameter fixes the direction. In the default receive variant, the channel writes the byte captured from the port into memory. In the transmit variant, it reads memory and returns the byte to the port. Address or count writes that arrive while a beat is open are held back and take effect when that beat completes.

The controller has four states:
- `ST_IDLE`: waiting for a request.
- `ST_ARB`: requesting the bus.
- `ST_BUSY`: the beat was granted and the channel waits for completion.
- `ST_RETIRE`: a one-cycle acknowledge back to the port.

The transitions are:
- IDLE→ARB on a request with a nonzero count.
- ARB→BUSY on grant.
- BUSY→RETIRE on done.
- RETIRE→IDLE always.

Top module: `uart_dma_chan`

## Requirements
- R1: After reset, `ptr_o`=0, `cnt_o`=0, `end_flag_o`=0, `irq_o`=0, `mem_req`=0 and `per_ack`=0.
- R2: While `cnt_o` is 0, `per_req` has no effect: `mem_req` stays 0 and `ptr_o` is unchanged.
- R3: With no beat open, a count write loads `cnt_o` on the next cycle. A nonzero count also clears `end_flag_o`.
- R4: One cycle after `per_req` is seen with a nonzero count, `mem_req` is 1 and `mem_addr` equals `ptr_o`. Both hold steady until `mem_gnt`.
- R5: One beat at most is open. `mem_req` is 0 from the cycle after grant until the beat has been retired.
- R6: On the cycle after `mem_done`, `per_ack` is 1 for exactly one cycle. By that cycle, `ptr_o` has advanced by XFER_BYTES (1, wrapping modulo 2^32) and `cnt_o` has dropped by one.
- R7: When a beat brings the count to 0, `end_flag_o` becomes 1. It stays 1 through zero-count writes until a nonzero count is written.
- R8: `irq_o` is 1 exactly when `end_flag_o` is 1 and the mask bit (bit 0 of `cfg_wdata` under `cfg_mask_we`) is 1.
- R9: Address or count writes made while `mem_req` or a granted beat is open do not change `ptr_o` or `cnt_o` at once. When the beat completes, they replace the stepped values.
- R10: Receive variant (default): `mem_we` is 1 and `mem_wdata` holds the `per_wdata` value present on the cycle the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ptr_we | input | 1 | Write address register from `cfg_wdata` |
| cfg_cnt_we | input | 1 | Write count register from `cfg_wdata[15:0]` |
| cfg_mask_we | input | 1 | Write interrupt mask from `cfg_wdata[0]` |
| cfg_wdata | input | 32 | Configuration write data |
| ptr_o | output | 32 | Current address register |
| cnt_o | output | 16 | Remaining transfer count |
| end_flag_o | output | 1 | End-of-transfer status |
| irq_o | output | 1 | Masked interrupt |
| per_req | input | 1 | Port data-ready request (level, held until ack) |
| per_wdata | input | 8 | Byte from the port (receive) |
| per_rdata | output | 8 | Byte returned to the port (transmit) |
| per_ack | output | 1 | One-cycle acknowledge of a finished beat |
| mem_req | output | 1 | Memory beat request |
| mem_gnt | input | 1 | Memory grant |
| mem_done | input | 1 | Memory beat completion |
| mem_addr | output | 32 | Memory address |
| mem_we | output | 1 | 1 = memory write, 0 = read |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data |

## Verification
The properties take for granted that the memory side is well behaved:
- `mem_gnt` comes only while `mem_req` is high.
- `mem_done` comes only after a grant, once per beat.
- The port keeps `per_req` high until it sees `per_ack`, and drops it right after.

The stimulus respects all of this. Grant and done are driven for one cycle only, inside the states that expect them. The request is released on the cycle after the acknowledge is sampled, so a released request never meets `ST_IDLE` again. Configuration writes are one-cycle pulses, placed either in idle or deliberately inside an open beat.

// File: rtl/udc_pkg.sv
package udc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARB    = 2'd1,
        ST_BUSY   = 2'd2,
        ST_RETIRE = 2'd3
    } chan_state_e;

endpackage

// File: rtl/udc_fsm.sv
module udc_fsm
    import udc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_nz,
    input  logic per_req,
    input  logic mem_gnt,
    input  logic mem_done,
    output logic mem_req,
    output logic per_ack,
    output logic take,
    output logic finish,
    output logic open_beat
);

    chan_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (per_req && cnt_nz) state_d = ST_ARB;
            ST_ARB:    if (mem_gnt)           state_d = ST_BUSY;
            ST_BUSY:   if (mem_done)          state_d = ST_RETIRE;
            ST_RETIRE:                        state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        per_ack   = 1'b0;
        take      = 1'b0;
        finish    = 1'b0;
        open_beat = 1'b0;
        unique case (state_q)
            ST_IDLE:   take = per_req && cnt_nz;
            ST_ARB: begin
                mem_req   = 1'b1;
                open_beat = 1'b1;
            end
            ST_BUSY: begin
                open_beat = 1'b1;
                finish    = mem_done;
            end
            ST_RETIRE: per_ack = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/udc_regs.sv
module udc_regs #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int XFER_BYTES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ptr_we,
    input  logic              cfg_cnt_we,
    input  logic              cfg_mask_we,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              open_beat,
    input  logic              finish,
    output logic [ADDR_W-1:0] ptr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              end_q,
    output logic              mask_q
);

    localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(XFER_BYTES);
    localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);

    logic [ADDR_W-1:0] pend_ptr;
    logic [CNT_W-1:0]  pend_cnt;
    logic              pend_ptr_v, pend_cnt_v;
    logic [CNT_W-1:0]  wr_cnt;
    logic              defer_ptr, defer_cnt;
    logic [ADDR_W-1:0] ptr_next;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_written;

    assign wr_cnt    = cfg_wdata[CNT_W-1:0];
    assign defer_ptr = cfg_ptr_we && open_beat && !finish;
    assign defer_cnt = cfg_cnt_we && open_beat && !finish;

    // values applied when a beat retires
    always_comb begin
        if (cfg_ptr_we)      ptr_next = cfg_wdata;
        else if (pend_ptr_v) ptr_next = pend_ptr;
        else                 ptr_next = ptr_q + STEP;

        cnt_written = 1'b1;
        if (cfg_cnt_we)      cnt_next = wr_cnt;
        else if (pend_cnt_v) cnt_next = pend_cnt;
        else begin
            cnt_next    = cnt_q - CNT_ONE;
            cnt_written = 1'b0;
        end
    end

    // deferred writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_ptr   <= '0;
            pend_cnt   <= '0;
            pend_ptr_v <= 1'b0;
            pend_cnt_v <= 1'b0;
        end else begin
            if (finish) begin
                pend_ptr_v <= 1'b0;
                pend_cnt_v <= 1'b0;
            end else begin
                if (defer_ptr) begin
                    pend_ptr   <= cfg_wdata;
                    pend_ptr_v <= 1'b1;
                end
                if (defer_cnt) begin
                    pend_cnt   <= wr_cnt;
                    pend_cnt_v <= 1'b1;
                end
            end
        end
    end

    // architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            cnt_q  <= '0;
            end_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (cfg_mask_we) mask_q <= cfg_wdata[0];
            if (finish) begin
                ptr_q <= ptr_next;
                cnt_q <= cnt_next;
                if (cnt_written) begin
                    if (cnt_next != '0) end_q <= 1'b0;
                end else if (cnt_q == CNT_ONE) begin
                    end_q <= 1'b1;
                end
            end else if (!open_beat) begin
                if (cfg_ptr_we) ptr_q <= cfg_wdata;
                if (cfg_cnt_we) begin
                    cnt_q <= wr_cnt;
                    if (wr_cnt != '0) end_q <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/udc_datapath.sv
module udc_datapath #(
    parameter int DATA_W = 8,
    parameter bit DIR_RX = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              finish,
    input  logic [DATA_W-1:0] per_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] per_rdata,
    output logic              mem_we
);

    logic [DATA_W-1:0] wr_hold, rd_hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_hold <= '0;
            rd_hold <= '0;
        end else begin
            if (take)   wr_hold <= per_wdata;
            if (finish) rd_hold <= mem_rdata;
        end
    end

    generate
        if (DIR_RX) begin : g_rx
            assign mem_we = 1'b1;
        end else begin : g_tx
            assign mem_we = 1'b0;
        end
    endgenerate

    assign mem_wdata = wr_hold;
    assign per_rdata = rd_hold;

endmodule

// File: rtl/uart_dma_chan.sv
module uart_dma_chan #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int DATA_W     = 8,
    parameter int XFER_BYTES = 1,
    parameter bit DIR_RX     = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_ptr_we,
    input  logic              cfg_cnt_we,
    input  logic              cfg_mask_we,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic              end_flag_o,
    output logic              irq_o,
    input  logic              per_req,
    input  logic [DATA_W-1:0] per_wdata,
    output logic [DATA_W-1:0] per_rdata,
    output logic              per_ack,
    output logic              mem_req,
    input  logic              mem_gnt,
    input  logic              mem_done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    logic take, finish, open_beat, mask_q;

    udc_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_nz    (cnt_o != '0),
        .per_req   (per_req),
        .mem_gnt   (mem_gnt),
        .mem_done  (mem_done),
        .mem_req   (mem_req),
        .per_ack   (per_ack),
        .take      (take),
        .finish    (finish),
        .open_beat (open_beat)
    );

    udc_regs #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .XFER_BYTES (XFER_BYTES)
    ) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_ptr_we  (cfg_ptr_we),
        .cfg_cnt_we  (cfg_cnt_we),
        .cfg_mask_we (cfg_mask_we),
        .cfg_wdata   (cfg_wdata),
        .open_beat   (open_beat),
        .finish      (finish),
        .ptr_q       (ptr_o),
        .cnt_q       (cnt_o),
        .end_q       (end_flag_o),
        .mask_q      (mask_q)
    );

    udc_datapath #(
        .DATA_W (DATA_W),
        .DIR_RX (DIR_RX)
    ) dp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .finish    (finish),
        .per_wdata (per_wdata),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .per_rdata (per_rdata),
        .mem_we    (mem_we)
    );

    assign mem_addr = ptr_o;
    assign irq_o    = end_flag_o & mask_q;

endmodule

// File: rtl/udc_chk.sv
module udc_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_ptr_we,
    input logic              cfg_cnt_we,
    input logic [ADDR_W-1:0] ptr_o,
    input logic [CNT_W-1:0]  cnt_o,
    input logic              end_flag_o,
    input logic              irq_o,
    input logic              per_ack,
    input logic              mem_req,
    input logic              mem_gnt,
    input logic [ADDR_W-1:0] mem_addr
);

    a_r2_zero_count_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == '0 && !mem_req && !cfg_cnt_we) |=> !mem_req);

    a_r4_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    a_r5_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt) |=> !mem_req);

    a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);

    a_r7_end_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag_o) |-> (cnt_o == '0));

    a_r8_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> end_flag_o);

    a_r9_defer_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && cfg_ptr_we) |=> (ptr_o == $past(ptr_o)));

endmodule

bind uart_dma_chan udc_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_ptr_we (cfg_ptr_we),
    .cfg_cnt_we (cfg_cnt_we),
    .ptr_o      (ptr_o),
    .cnt_o      (cnt_o),
    .end_flag_o (end_flag_o),
    .irq_o      (irq_o),
    .per_ack    (per_ack),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr)
);

// File: tb/uart_dma_chan_tb_top.sv
module uart_dma_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_ptr_we = 1'b0, cfg_cnt_we = 1'b0, cfg_mask_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] ptr_o, mem_addr;
    logic [15:0] cnt_o;
    logic        end_flag_o, irq_o, per_ack, mem_req, mem_we;
    logic        per_req = 1'b0, mem_gnt = 1'b0, mem_done = 1'b0;
    logic [7:0]  per_wdata = '0, mem_rdata = '0, per_rdata, mem_wdata;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #10 clk = ~clk;

    uart_dma_chan dut_i (.*);

    typedef struct packed {
        logic [31:0] ptr;
        logic [15:0] cnt;
        logic [3:0]  gw;
        logic [3:0]  dw;
        logic [7:0]  dat;
        logic        mask;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_1000, 16'd5,      4'd0, 4'd0, 8'hA5, 1'b0},
        '{32'h0000_2FFF, 16'd2,      4'd3, 4'd1, 8'h3C, 1'b1},
        '{32'hFFFF_FFFF, 16'd9,      4'd1, 4'd4, 8'h00, 1'b0},
        '{32'h8000_0000, 16'd1,      4'd2, 4'd2, 8'hFF, 1'b1},
        '{32'h1234_5678, 16'd1,      4'd0, 4'd3, 8'h5A, 1'b0},
        '{32'h0000_0010, 16'hFFFF,   4'd5, 4'd0, 8'h81, 1'b1}
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic p, input logic c, input logic m, input logic [31:0] d);
        cfg_ptr_we = p; cfg_cnt_we = c; cfg_mask_we = m; cfg_wdata = d;
        @(negedge clk);
        cfg_ptr_we = 0; cfg_cnt_we = 0; cfg_mask_we = 0;
    endtask

    // one beat; caller is at a negedge in idle
    task automatic beat(input logic [31:0] exp_addr, input logic [7:0] d,
                        input int gw, input int dw);
        per_req = 1; per_wdata = d;
        @(negedge clk);
        per_wdata = ~d;
        chk("R4 mem_req", {31'd0, mem_req}, 32'd1);
        chk("R4 mem_addr", mem_addr, exp_addr);
        chk("R10 mem_wdata", {24'd0, mem_wdata}, {24'd0, d});
        chk("R10 mem_we", {31'd0, mem_we}, 32'd1);
        for (int i = 0; i < gw; i++) begin
            @(negedge clk);
            chk("R4 held", {mem_req, mem_addr[30:0]}, {1'b1, exp_addr[30:0]});
        end
        mem_gnt = 1;
        @(negedge clk);
        mem_gnt = 0;
        chk("R5 req drop", {31'd0, mem_req}, 32'd0);
        for (int i = 0; i < dw; i++) begin
            @(negedge clk);
            chk("R5 no req", {mem_req, per_ack}, 32'd0);
        end
        mem_done = 1;
        @(negedge clk);
        mem_done = 0;
        chk("R6 ack", {31'd0, per_ack}, 32'd1);
        per_req = 0;
        @(negedge clk);
        chk("R6 ack pulse", {31'd0, per_ack}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 ptr", ptr_o, 0);
        chk("R1 cnt", {16'd0, cnt_o}, 0);
        chk("R1 flags", {end_flag_o, irq_o, mem_req, per_ack}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2: zero count ignores requests
        per_req = 1;
        repeat (4) begin
            @(negedge clk);
            chk("R2 no req", {31'd0, mem_req}, 32'd0);
        end
        per_req = 0;
        chk("R2 ptr", ptr_o, 0);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            wr(1, 0, 0, VEC[v].ptr);
            wr(0, 0, 1, {31'd0, VEC[v].mask});
            wr(0, 1, 0, {16'd0, VEC[v].cnt});
            chk("R3 cnt load", {16'd0, cnt_o}, {16'd0, VEC[v].cnt});
            beat(VEC[v].ptr, VEC[v].dat, VEC[v].gw, VEC[v].dw);
            chk("R6 ptr step", ptr_o, VEC[v].ptr + 32'd1);
            chk("R6 cnt dec", {16'd0, cnt_o}, {16'd0, VEC[v].cnt - 16'd1});
            chk("R7 end", {31'd0, end_flag_o}, {31'd0, VEC[v].cnt == 16'd1});
            chk("R8 irq", {31'd0, irq_o}, {31'd0, (VEC[v].cnt == 16'd1) && VEC[v].mask});
        end

        // after last-ending vector: flag persistence and mask (R7, R8)
        wr(1, 0, 0, 32'h40);
        wr(0, 1, 0, 32'd1);
        wr(0, 0, 1, 32'd1);
        beat(32'h40, 8'h11, 0, 0);
        chk("R7 end set", {31'd0, end_flag_o}, 32'd1);
        chk("R8 irq on", {31'd0, irq_o}, 32'd1);
        wr(0, 0, 1, 32'd0);
        chk("R8 irq masked", {31'd0, irq_o}, 32'd0);
        wr(0, 1, 0, 32'd0);
        chk("R7 zero write keeps", {31'd0, end_flag_o}, 32'd1);
        wr(0, 1, 0, 32'd2);
        chk("R3 clear end", {31'd0, end_flag_o}, 32'd0);

        // R9: writes during an open beat
        wr(1, 0, 0, 32'h100);
        wr(0, 1, 0, 32'd5);
        per_req = 1; per_wdata = 8'h77;
        @(negedge clk);
        chk("R9 in arb", {31'd0, mem_req}, 32'd1);
        wr(1, 0, 0, 32'h2000);
        chk("R9 ptr held", ptr_o, 32'h100);
        wr(0, 1, 0, 32'd3);
        chk("R9 cnt held", {16'd0, cnt_o}, 32'd5);
        chk("R4 addr held", mem_addr, 32'h100);
        mem_gnt = 1;
        @(negedge clk);
        mem_gnt = 0;
        mem_done = 1;
        @(negedge clk);
        mem_done = 0;
        chk("R9 ptr applied", ptr_o, 32'h2000);
        chk("R9 cnt applied", {16'd0, cnt_o}, 32'd3);
        per_req = 0;
        @(negedge clk);

        ended = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule